// File: doc/BRIEF.md
# UART FIFO Control and Status Wrapper

This block sits between a UART's serial engine and the system bus. It holds a transmit FIFO and a receive FIFO, and it presents four word registers on an APB-style bus. These are a status word, the fill level of each FIFO, and a write-only reset word. The serial engine pops bytes from the transmit FIFO and pushes received bytes into the receive FIFO. Software watches the levels and the transmit-space flag to pace its traffic.

The reset word lets software empty either FIFO without reissuing the FIFO control settings. Each bit written as 1 becomes a one-cycle internal pulse, and the bit never holds state. A third bit resets the UART controller itself. That reset takes hold at once, without waiting for a clock edge. It is released only after two clean clock edges through a synchroniser, and the FIFOs stay cleared for as long as it is held.

Register selection uses address bits [3:2]: 0 is status, 1 is the transmit level, 2 is the receive level and 3 is the reset word. Reads are zero-wait. Read data is captured on the setup phase and is valid during the access phase. Writes take effect on the access-phase edge.

Top module: `uart_fifo_ctl`

## Requirements
- R1: The status word (select 0) reads bit 1 as 1 while the transmit FIFO has a free entry and as 0 when it is full. Bit 0 and bits 15:2 read 0, so the value after reset is 0x0002.
- R2: The transmit level word (select 1) reads the number of entries held in the transmit FIFO, zero-extended to 16 bits. Its value after reset is 0.
- R3: The receive level word (select 2) reads the number of entries held in the receive FIFO, zero-extended to 16 bits. Its value after reset is 0.
- R4: Writing the reset word (select 3) with bit 2 set empties the transmit FIFO through a one-cycle pulse. The transmit level reads 0 afterwards, `tx_empty` is 1, and the receive FIFO keeps its contents.
- R5: Writing the reset word with bit 1 set empties the receive FIFO the same way and leaves the transmit FIFO untouched.
- R6: A FIFO-empty pulse overrides a push presented in the same cycle, so the level is 0 on the following cycle.
- R7: Writing the reset word with bit 0 set raises `ctl_rst_o` at once, in the cycle after the write edge, with no extra clock edge. It holds `ctl_rst_o` high for the two following edges and drops it after the third. Both FIFOs are empty once it is released, and pushes made while it is high are dropped.
- R8: The reset word always reads 0. Writing only its bits 15:3 changes neither FIFO.
- R9: Each FIFO holds `DEPTH` entries (16 by default). A push to a full FIFO is dropped and the level stays at `DEPTH`. Entries leave in the order they arrived.
- R10: A pop from an empty FIFO is ignored and the level stays 0. Popped data appears on the read-data port one cycle after the pop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | Bus write strobe |
| paddr | input | ADDR_W | Bus byte address; bits [3:2] pick the register |
| pwdata | input | 16 | Bus write data |
| prdata | output | 16 | Bus read data, registered |
| tx_push | input | 1 | Push a byte into the transmit FIFO |
| tx_wdata | input | DATA_W | Transmit FIFO write data |
| tx_pop | input | 1 | Serial engine pops a byte from the transmit FIFO |
| tx_rdata | output | DATA_W | Transmit FIFO read data, valid one cycle after a pop |
| tx_empty | output | 1 | Transmit FIFO holds no entry |
| rx_push | input | 1 | Serial engine pushes a received byte |
| rx_wdata | input | DATA_W | Receive FIFO write data |
| rx_pop | input | 1 | Pop a byte from the receive FIFO |
| rx_rdata | output | DATA_W | Receive FIFO read data, valid one cycle after a pop |
| rx_empty | output | 1 | Receive FIFO holds no entry |
| ctl_rst_o | output | 1 | UART controller reset, asserted immediately, released synchronously |

## Verification
The bench walks both FIFOs through interleaved pushes and pops. It checks levels and data order after every step, so a design that mixed up the two counters or read from the wrong pointer would report a wrong level or a wrong byte. It then fills the transmit FIFO and pushes once more. A design with no saturation would wrap the level to 0 or overwrite the oldest byte, and would also leave the not-full flag set.

Several corner cases are timed to the cycle. A push is placed in the same cycle as an empty pulse, and a design that let the push win would leave a level of 1. The controller reset is sampled edge by edge to catch an assertion that waits for a clock, or a release that comes a cycle early or late. Writes to only the reserved reset bits must leave the levels unchanged, and a design that decoded them would empty a FIFO.

// File: rtl/uart_fifo_ctl_pkg.sv
package uart_fifo_ctl_pkg;
  localparam int REG_W = 16;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_TX_LVL = 2'd1,
    SEL_RX_LVL = 2'd2,
    SEL_SRESET = 2'd3
  } reg_sel_e;

  // bit positions inside the reset word
  localparam int SR_CTL_BIT = 0;
  localparam int SR_RX_BIT  = 1;
  localparam int SR_TX_BIT  = 2;
  // bit position of the transmit-space flag in the status word
  localparam int ST_TX_NF_BIT = 1;
endpackage

// File: rtl/uart_reset_sync.sv
module uart_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst,
  output logic rst_o
);
  logic [STAGES-1:0] stage_q;

  // asynchronous assertion, release shifted in over STAGES edges
  always_ff @(posedge clk or posedge arst) begin
    if (arst) stage_q <= '1;
    else      stage_q <= {stage_q[STAGES-2:0], 1'b0};
  end

  assign rst_o = stage_q[STAGES-1];
endmodule

// File: rtl/uart_sync_fifo.sv
module uart_sync_fifo #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              push,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop,
  output logic [DATA_W-1:0] rdata,
  output logic              empty,
  output logic              full,
  output logic [CNT_W-1:0]  level
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              do_push, do_pop;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_FULL);
  assign level   = cnt_q;
  assign do_push = push && !full && !clr && !rst;
  assign do_pop  = pop && !empty && !clr && !rst;

  // storage: write port and registered read port, no reset
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr_q] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (do_pop) rdata <= mem[rd_ptr_q];
  end

  // control: pointers and count, cleared by reset or the empty pulse
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !clr) |=> (full && level == CNT_FULL));

  // R10
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    (empty && pop && !push && !clr) |=> empty);

  // R6
  clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (level == '0 && empty));
endmodule

// File: rtl/uart_fifo_regs.sv
module uart_fifo_regs
  import uart_fifo_ctl_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [REG_W-1:0]  pwdata,
  output logic [REG_W-1:0]  prdata,
  input  logic [CNT_W-1:0]  tx_level,
  input  logic [CNT_W-1:0]  rx_level,
  input  logic              tx_full,
  output logic              tx_clr_o,
  output logic              rx_clr_o,
  output logic              ctl_req_o
);
  reg_sel_e         sel;
  logic             wr_en, rd_setup, sr_wr;
  logic [REG_W-1:0] rd_mux;

  assign sel      = reg_sel_e'(paddr[3:2]);
  assign wr_en    = psel && penable && pwrite;
  assign rd_setup = psel && !penable && !pwrite;
  assign sr_wr    = wr_en && (sel == SEL_SRESET);

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_STATUS: rd_mux[ST_TX_NF_BIT] = !tx_full;
      SEL_TX_LVL: rd_mux = REG_W'(tx_level);
      SEL_RX_LVL: rd_mux = REG_W'(rx_level);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prdata    <= '0;
      tx_clr_o  <= 1'b0;
      rx_clr_o  <= 1'b0;
      ctl_req_o <= 1'b0;
    end else begin
      tx_clr_o  <= sr_wr && pwdata[SR_TX_BIT];
      rx_clr_o  <= sr_wr && pwdata[SR_RX_BIT];
      ctl_req_o <= sr_wr && pwdata[SR_CTL_BIT];
      if (rd_setup) prdata <= rd_mux;
    end
  end

  logic unused_bits;
  assign unused_bits = &{1'b0, paddr[1:0], pwdata[REG_W-1:3]};

  // R8
  sreset_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_setup && sel == SEL_SRESET) |=> (prdata == '0));

  // R1
  status_reserved_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_setup && sel == SEL_STATUS) |=> (prdata[0] == 1'b0 && prdata[REG_W-1:2] == '0));

  // R4
  tx_pulse_once_chk: assert property (@(posedge clk) disable iff (rst)
    tx_clr_o |=> !tx_clr_o);
endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
  import uart_fifo_ctl_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 4,
  parameter int SYNC_ST = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [15:0]       pwdata,
  output logic [15:0]       prdata,
  input  logic              tx_push,
  input  logic [DATA_W-1:0] tx_wdata,
  input  logic              tx_pop,
  output logic [DATA_W-1:0] tx_rdata,
  output logic              tx_empty,
  input  logic              rx_push,
  input  logic [DATA_W-1:0] rx_wdata,
  input  logic              rx_pop,
  output logic [DATA_W-1:0] rx_rdata,
  output logic              rx_empty,
  output logic              ctl_rst_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             tx_clr, rx_clr, ctl_req, ctl_arst, ctl_rst;
  logic             tx_full, rx_full;
  logic [CNT_W-1:0] tx_level, rx_level;

  uart_fifo_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) regs_i (
    .clk      (clk),
    .rst      (rst),
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr    (paddr),
    .pwdata   (pwdata),
    .prdata   (prdata),
    .tx_level (tx_level),
    .rx_level (rx_level),
    .tx_full  (tx_full),
    .tx_clr_o (tx_clr),
    .rx_clr_o (rx_clr),
    .ctl_req_o(ctl_req)
  );

  assign ctl_arst = rst || ctl_req;

  uart_reset_sync #(.STAGES(SYNC_ST)) rsync_i (
    .clk  (clk),
    .arst (ctl_arst),
    .rst_o(ctl_rst)
  );

  assign ctl_rst_o = ctl_rst;

  uart_sync_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W)) tx_fifo_i (
    .clk  (clk),
    .rst  (ctl_rst),
    .clr  (tx_clr),
    .push (tx_push),
    .wdata(tx_wdata),
    .pop  (tx_pop),
    .rdata(tx_rdata),
    .empty(tx_empty),
    .full (tx_full),
    .level(tx_level)
  );

  uart_sync_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W)) rx_fifo_i (
    .clk  (clk),
    .rst  (ctl_rst),
    .clr  (rx_clr),
    .push (rx_push),
    .wdata(rx_wdata),
    .pop  (rx_pop),
    .rdata(rx_rdata),
    .empty(rx_empty),
    .full (rx_full),
    .level(rx_level)
  );

  logic unused_full;
  assign unused_full = rx_full;

  // R7
  ctl_rst_immediate_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_req |-> ctl_rst_o);

  // R7
  ctl_rst_empties_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(ctl_rst_o)) |-> (tx_empty && rx_empty));
endmodule

// File: tb/uart_fifo_ctl_tb_top.sv
module uart_fifo_ctl_tb_top;
  localparam int DEPTH  = 16;
  localparam int DATA_W = 8;
  localparam int NVEC   = 10;
  // entry: {op[1:0], data[7:0], exp_tx_level[4:0], exp_rx_level[4:0]}
  // op 0 push tx, 1 push rx, 2 pop tx (data = expected), 3 pop rx
  localparam logic [19:0] VEC [NVEC] = '{
    {2'd0, 8'hA1, 5'd1, 5'd0},
    {2'd0, 8'hB2, 5'd2, 5'd0},
    {2'd1, 8'h33, 5'd2, 5'd1},
    {2'd0, 8'hC4, 5'd3, 5'd1},
    {2'd2, 8'hA1, 5'd2, 5'd1},
    {2'd1, 8'h44, 5'd2, 5'd2},
    {2'd3, 8'h33, 5'd2, 5'd1},
    {2'd2, 8'hB2, 5'd1, 5'd1},
    {2'd2, 8'hC4, 5'd0, 5'd1},
    {2'd3, 8'h44, 5'd0, 5'd0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [3:0] paddr = '0;
  logic [15:0] pwdata = '0;
  logic [15:0] prdata;
  logic tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0;
  logic [DATA_W-1:0] tx_wdata = '0, rx_wdata = '0;
  logic [DATA_W-1:0] tx_rdata, rx_rdata;
  logic tx_empty, rx_empty, ctl_rst_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  uart_fifo_ctl #(.DEPTH(DEPTH), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
    .tx_empty(tx_empty), .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop),
    .rx_rdata(rx_rdata), .rx_empty(rx_empty), .ctl_rst_o(ctl_rst_o)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic apb_write(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_read(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); psel = 1; pwrite = 0; penable = 0; paddr = a;
    @(negedge clk); penable = 1; d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic push_tx(input logic [7:0] d);
    @(negedge clk); tx_push = 1; tx_wdata = d;
    @(negedge clk); tx_push = 0;
  endtask

  task automatic push_rx(input logic [7:0] d);
    @(negedge clk); rx_push = 1; rx_wdata = d;
    @(negedge clk); rx_push = 0;
  endtask

  task automatic pop_tx(output logic [7:0] d);
    @(negedge clk); tx_pop = 1;
    @(negedge clk); tx_pop = 0; d = tx_rdata;
  endtask

  task automatic pop_rx(output logic [7:0] d);
    @(negedge clk); rx_pop = 1;
    @(negedge clk); rx_pop = 0; d = rx_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    logic [7:0] b;
    repeat (4) @(negedge clk);
    rst = 0;
    repeat (3) @(negedge clk);

    // reset state
    check("R7 ctl reset released", {15'd0, ctl_rst_o}, 16'd0);
    apb_read(4'h0, r); check("R1 status after reset", r, 16'h0002);
    apb_read(4'h4, r); check("R2 tx level after reset", r, 16'd0);
    apb_read(4'h8, r); check("R3 rx level after reset", r, 16'd0);

    // vector walk
    for (int i = 0; i < NVEC; i++) begin
      case (VEC[i][19:18])
        2'd0: push_tx(VEC[i][17:10]);
        2'd1: push_rx(VEC[i][17:10]);
        2'd2: begin pop_tx(b); check("R9 tx order", {8'd0, b}, {8'd0, VEC[i][17:10]}); end
        default: begin pop_rx(b); check("R9 rx order", {8'd0, b}, {8'd0, VEC[i][17:10]}); end
      endcase
      apb_read(4'h4, r); check("R2 tx level", r, {11'd0, VEC[i][9:5]});
      apb_read(4'h8, r); check("R3 rx level", r, {11'd0, VEC[i][4:0]});
    end

    // R10 pop from empty
    pop_tx(b);
    apb_read(4'h4, r); check("R10 pop empty level", r, 16'd0);
    check("R10 tx_empty", {15'd0, tx_empty}, 16'd1);

    // R9 fill and overflow
    for (int i = 0; i < DEPTH; i++) push_tx(8'h10 + 8'(i));
    apb_read(4'h4, r); check("R9 full level", r, 16'd16);
    apb_read(4'h0, r); check("R1 status full", r, 16'h0000);
    push_tx(8'hEE);
    apb_read(4'h4, r); check("R9 push on full dropped", r, 16'd16);
    pop_tx(b); check("R9 oldest first", {8'd0, b}, 16'h0010);
    apb_read(4'h0, r); check("R1 status not full", r, 16'h0002);

    // R4 transmit empty pulse, rx untouched
    push_rx(8'h51); push_rx(8'h52);
    apb_write(4'hC, 16'h0004);
    apb_read(4'h4, r); check("R4 tx level cleared", r, 16'd0);
    check("R4 tx_empty", {15'd0, tx_empty}, 16'd1);
    apb_read(4'h8, r); check("R4 rx kept", r, 16'd2);

    // R5 receive empty pulse, tx untouched
    push_tx(8'h61);
    apb_write(4'hC, 16'h0002);
    apb_read(4'h8, r); check("R5 rx level cleared", r, 16'd0);
    apb_read(4'h4, r); check("R5 tx kept", r, 16'd1);
    push_tx(8'h62); pop_tx(b); check("R5 tx data kept", {8'd0, b}, 16'h0061);

    // R6 pulse beats a push in the same cycle (tx holds 1 entry)
    apb_write(4'hC, 16'h0004);
    tx_push = 1; tx_wdata = 8'h77;
    @(negedge clk); tx_push = 0;
    apb_read(4'h4, r); check("R6 clear beats push", r, 16'd0);

    // R8 reserved writes and read-back
    push_tx(8'h81);
    apb_write(4'hC, 16'hFFF8);
    apb_read(4'h4, r); check("R8 reserved write no effect", r, 16'd1);
    apb_read(4'hC, r); check("R8 reset word reads zero", r, 16'd0);

    // R7 controller reset
    push_rx(8'h91);
    apb_write(4'hC, 16'h0001);
    check("R7 asserted immediately", {15'd0, ctl_rst_o}, 16'd1);
    tx_push = 1; tx_wdata = 8'h99;
    @(negedge clk); tx_push = 0;
    check("R7 held after first edge", {15'd0, ctl_rst_o}, 16'd1);
    @(negedge clk);
    check("R7 held after second edge", {15'd0, ctl_rst_o}, 16'd1);
    @(negedge clk);
    check("R7 released after third edge", {15'd0, ctl_rst_o}, 16'd0);
    apb_read(4'h4, r); check("R7 tx emptied", r, 16'd0);
    apb_read(4'h8, r); check("R7 rx emptied", r, 16'd0);
    push_tx(8'hA5); pop_tx(b); check("R7 works after release", {8'd0, b}, 16'h00A5);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule